// File: doc/BRIEF.md
# Byte-wide asynchronous serial adapter

This block is a small asynchronous serial controller for eight-bit characters. Software sees four registers. A write-only control byte selects the clock ratio, the character format and the transmit and receive behaviour. A read-only status byte reports the state of the data holding registers, the two modem inputs, three receive error flags and a combined interrupt request. A transmit data register takes the next character, and a receive data register holds the last character assembled. Each register has its own strobe, so the surrounding address decoder stays outside the block.

The transmitter turns a held byte into a frame: a low start bit, the data bits least significant bit first, an optional parity bit, then one or two high stop bits. The receiver runs the mirror process on the incoming line. It resynchronises to each start edge and samples every bit in the middle of its period. One divide code is not a ratio at all: it holds the whole adapter in master reset until a real ratio is written.

Top module: `sio_adapter`

## Requirements
- R1: After `rst_n` is sampled low, the control register holds the master-reset code (control byte 0x03). Status then reads 0 apart from bits 2 and 3, `tx_line` is high and `rts_out` is low.
- R2: While control bits 1:0 equal 3, status bits 0, 1, 4, 5, 6 and 7 read 0, `tx_line` stays high unless a break is selected, and transmit data writes are discarded. Writing divide code 0, 1 or 2 resumes operation with status bit 1 (transmit empty) set.
- R3: Control bits 1:0 set the bit period in clock cycles: code 0 gives 1, code 1 gives 16 and code 2 gives 64. The period applies to both directions.
- R4: Control bits 4:2 pick the frame: 0 = 7 data bits, even parity, 2 stop; 1 = 7, odd, 2; 2 = 7, even, 1; 3 = 7, odd, 1; 4 = 8, no parity, 2; 5 = 8, none, 1; 6 = 8, even, 1; 7 = 8, odd, 1. A frame is a 0 start bit, the data bits LSB first, then parity if any, then stop bits at 1. A received 7-bit character reads back with bit 7 at 0.
- R5: Control bits 6:5 give `rts_out` = 1 for code 2 and 0 otherwise. Code 3 forces `tx_line` low for as long as it stays selected.
- R6: Status bit 1 (transmit empty) drops when the transmit data register is written. It returns to 1 only once the transmit shifter has taken the byte, so a second byte written during a frame keeps it at 0 until that frame ends.
- R7: At divide codes 1 and 2, the receiver checks the start bit again half a bit period after the falling edge. If the line is high by then, the receiver returns to idle and assembles nothing.
- R8: A completed character sets status bit 0 (receive full). A pulse on `rxd_rd` clears status bits 0, 4, 5 and 6.
- R9: Status bit 4 (framing error) is set when the first stop bit is sampled low. Status bit 6 (parity error) is set when the received parity does not match the selected even or odd sense.
- R10: If a character completes while status bit 0 is still set, status bit 5 (overrun) is set and `rx_byte` keeps the unread character.
- R11: Status bit 7 and `irq` equal (control bit 7 AND status bit 0) OR (control bits 6:5 = 1 AND status bit 1).
- R12: Status bit 2 follows `dcd_in` and status bit 3 follows `cts_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Write strobe for the control register |
| txd_we | input | 1 | Write strobe for the transmit data register |
| rxd_rd | input | 1 | Read strobe for the receive data register (clears flags) |
| wdata | input | 8 | Write data for both writable registers |
| status | output | 8 | Status register contents |
| rx_byte | output | 8 | Receive data register contents |
| rx_line | input | 1 | Serial input line |
| tx_line | output | 1 | Serial output line |
| rts_out | output | 1 | Request-to-send level |
| dcd_in | input | 1 | Carrier-detect modem input |
| cts_in | input | 1 | Clear-to-send modem input |
| irq | output | 1 | Interrupt request, same value as status bit 7 |

## Verification
The embedded properties assume three things. A strobe is driven for one cycle per access. The control and transmit strobes are never raised in the same cycle. `rx_line` holds each bit level for a whole bit period, apart from the deliberate glitch used to test start-bit rejection. The bench writes through tasks that raise exactly one strobe for one cycle. It drives every serial bit for exactly the configured divide count. Its receive pulses are issued only between characters, so a read never lands in the same cycle as a completing stop bit.

// File: rtl/sio_pkg.sv
// Shared types for the serial adapter: control byte layout, divide and
// transmit-control codes, and the decoded character format.
// Assumes eight-bit data and at most two stop bits.
package sio_pkg;

    localparam int DATA_W    = 8;
    localparam int FRAME_MAX = 1 + DATA_W + 1 + 2;

    typedef enum logic [1:0] {
        DIV_X1   = 2'd0,
        DIV_X16  = 2'd1,
        DIV_X64  = 2'd2,
        DIV_MRST = 2'd3
    } div_e;

    typedef enum logic [1:0] {
        TC_LO_QUIET = 2'd0,
        TC_LO_IRQ   = 2'd1,
        TC_HI_QUIET = 2'd2,
        TC_BREAK    = 2'd3
    } tctl_e;

    // Packed from bit 7 down to bit 0.
    typedef struct packed {
        logic       rx_ie;
        tctl_e      tctl;
        logic [2:0] fmt;
        div_e       div;
    } ctrl_t;

    typedef struct packed {
        logic d8;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } fmt_t;

    // Turns the 3-bit format code into its frame properties.
    function automatic fmt_t fmt_decode(input logic [2:0] code);
        fmt_t f;
        case (code)
            3'd0: f = '{d8: 1'b0, par_en: 1'b1, par_odd: 1'b0, two_stop: 1'b1};
            3'd1: f = '{d8: 1'b0, par_en: 1'b1, par_odd: 1'b1, two_stop: 1'b1};
            3'd2: f = '{d8: 1'b0, par_en: 1'b1, par_odd: 1'b0, two_stop: 1'b0};
            3'd3: f = '{d8: 1'b0, par_en: 1'b1, par_odd: 1'b1, two_stop: 1'b0};
            3'd4: f = '{d8: 1'b1, par_en: 1'b0, par_odd: 1'b0, two_stop: 1'b1};
            3'd5: f = '{d8: 1'b1, par_en: 1'b0, par_odd: 1'b0, two_stop: 1'b0};
            3'd6: f = '{d8: 1'b1, par_en: 1'b1, par_odd: 1'b0, two_stop: 1'b0};
            default: f = '{d8: 1'b1, par_en: 1'b1, par_odd: 1'b1, two_stop: 1'b0};
        endcase
        return f;
    endfunction

endpackage

// File: rtl/sio_ctrl.sv
// Control register and its decode.
// Holds the write-only control byte and turns it into the master-reset,
// break, RTS, interrupt-enable, format and bit-period controls.
// Assumes the three divide ratios are ascending and the largest fits CNT_W.
module sio_ctrl
    import sio_pkg::*;
#(
    parameter int P_X1  = 1,
    parameter int P_X16 = 16,
    parameter int P_X64 = 64,
    localparam int CNT_W = $clog2(P_X64 + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [7:0]       wdata,
    output logic             mrst,
    output logic             brk,
    output logic             rts,
    output logic             rx_ie,
    output logic             tx_ie,
    output fmt_t             fmt,
    output logic [CNT_W-1:0] bit_last,
    output logic [CNT_W-1:0] half_last,
    output logic             single
);

    ctrl_t q;

    // Control byte storage; reset parks the adapter in master reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= ctrl_t'(8'h03);
        end else if (we) begin
            q <= ctrl_t'(wdata);
        end
    end

    // Field decode into individual controls.
    always_comb begin
        mrst  = (q.div == DIV_MRST);
        brk   = (q.tctl == TC_BREAK);
        rts   = (q.tctl == TC_HI_QUIET);
        tx_ie = (q.tctl == TC_LO_IRQ);
        rx_ie = q.rx_ie;
        fmt   = fmt_decode(q.fmt);
    end

    // Bit-period and half-period counter limits for the selected ratio.
    always_comb begin
        case (q.div)
            DIV_X1: begin
                bit_last  = CNT_W'(P_X1 - 1);
                half_last = CNT_W'((P_X1 > 1) ? (P_X1 / 2 - 1) : 0);
            end
            DIV_X16: begin
                bit_last  = CNT_W'(P_X16 - 1);
                half_last = CNT_W'(P_X16 / 2 - 1);
            end
            DIV_X64: begin
                bit_last  = CNT_W'(P_X64 - 1);
                half_last = CNT_W'(P_X64 / 2 - 1);
            end
            default: begin
                bit_last  = '0;
                half_last = '0;
            end
        endcase
        single = (bit_last == '0);
    end

    AST_RESET_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> mrst) else $error("AST_RESET_PARKS"); // R1

endmodule

// File: rtl/sio_tx.sv
// Transmitter: one holding register feeding a frame shifter.
// The held byte is framed per the selected format and shifted out LSB
// first, one bit per bit period. Assumes bit_last is stable during a frame.
module sio_tx
    import sio_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrst,
    input  logic              brk,
    input  fmt_t              fmt,
    input  logic [CNT_W-1:0]  bit_last,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic              txd,
    output logic              tdre
);

    logic                 full;
    logic                 busy;
    logic                 load;
    logic                 par;
    logic [DATA_W-1:0]    hold;
    logic [FRAME_MAX-1:0] frame;
    logic [FRAME_MAX-1:0] sh;
    logic [3:0]           dlen;
    logic [3:0]           nbits;
    logic [3:0]           left;
    logic [CNT_W-1:0]     cnt;

    assign load = full && !busy;
    assign tdre = !full && !mrst;
    assign txd  = brk ? 1'b0 : (busy ? sh[0] : 1'b1);

    // Holding register: a write fills it, a shifter load empties it.
    always_ff @(posedge clk) begin
        if (!rst_n || mrst) begin
            full <= 1'b0;
            hold <= '0;
        end else if (we) begin
            full <= 1'b1;
            hold <= wdata;
        end else if (load) begin
            full <= 1'b0;
        end
    end

    // Frame assembly: start, data LSB first, optional parity, stop padding.
    always_comb begin
        dlen  = fmt.d8 ? 4'(DATA_W) : 4'(DATA_W - 1);
        par   = fmt.par_odd;
        frame = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (4'(i) < dlen) begin
                frame[1 + i] = hold[i];
                par = par ^ hold[i];
            end
        end
        if (fmt.par_en) begin
            frame[4'd1 + dlen] = par;
        end
        nbits = 4'd1 + dlen + (fmt.par_en ? 4'd1 : 4'd0) + (fmt.two_stop ? 4'd2 : 4'd1);
    end

    // Frame shifter: each bit is held for bit_last+1 cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || mrst) begin
            busy <= 1'b0;
            sh   <= '1;
            left <= '0;
            cnt  <= '0;
        end else if (load) begin
            busy <= 1'b1;
            sh   <= frame;
            left <= nbits - 4'd1;
            cnt  <= bit_last;
        end else if (busy) begin
            if (cnt == '0) begin
                if (left == '0) begin
                    busy <= 1'b0;
                end else begin
                    sh   <= {1'b1, sh[FRAME_MAX-1:1]};
                    left <= left - 4'd1;
                    cnt  <= bit_last;
                end
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        we && !mrst |=> !tdre) else $error("AST_WRITE_FILLS"); // R6
    AST_MRST_LINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mrst) && mrst && !brk |-> txd) else $error("AST_MRST_LINE_IDLE"); // R2

endmodule

// File: rtl/sio_rx.sv
// Receiver: line synchroniser, start validation, mid-bit sampling and the
// receive data register with its full and error flags.
// Assumes the line holds each bit for a full period at the selected ratio.
module sio_rx
    import sio_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrst,
    input  logic              d8,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [CNT_W-1:0]  bit_last,
    input  logic [CNT_W-1:0]  half_last,
    input  logic              single,
    input  logic              rxd,
    input  logic              rd,
    output logic              rdrf,
    output logic              fe,
    output logic              pe,
    output logic              ovrn,
    output logic [DATA_W-1:0] dreg
);

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_st_e;

    rx_st_e            st;
    logic              s1, s2;
    logic [CNT_W-1:0]  cnt;
    logic [3:0]        idx;
    logic [3:0]        nsamp;
    logic [DATA_W:0]   sh;
    logic [DATA_W-1:0] cap;
    logic              pbit;
    logic              pe_calc;
    logic              done;

    assign nsamp = (d8 ? 4'(DATA_W) : 4'(DATA_W - 1)) + (par_en ? 4'd1 : 4'd0);
    assign done  = (st == RX_STOP) && (cnt == '0);

    // Two-stage synchroniser on the serial input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= rxd;
            s2 <= s1;
        end
    end

    // Bit sequencer: detect, re-check start at mid-bit, then sample per period.
    always_ff @(posedge clk) begin
        if (!rst_n || mrst) begin
            st  <= RX_IDLE;
            cnt <= '0;
            idx <= '0;
            sh  <= '0;
        end else begin
            case (st)
                RX_IDLE: begin
                    idx <= '0;
                    if (!s2) begin
                        if (single) begin
                            st  <= RX_BITS;
                            cnt <= '0;
                        end else begin
                            st  <= RX_START;
                            cnt <= half_last;
                        end
                    end
                end
                RX_START: begin
                    if (cnt == '0) begin
                        st  <= s2 ? RX_IDLE : RX_BITS;
                        cnt <= bit_last;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                RX_BITS: begin
                    if (cnt == '0) begin
                        sh[idx] <= s2;
                        idx     <= idx + 4'd1;
                        cnt     <= bit_last;
                        if (idx == nsamp - 4'd1) begin
                            st <= RX_STOP;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        st <= RX_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    // Character extraction and parity check from the sampled bits.
    always_comb begin
        cap     = d8 ? sh[DATA_W-1:0] : {1'b0, sh[DATA_W-2:0]};
        pbit    = d8 ? sh[DATA_W] : sh[DATA_W-1];
        pe_calc = par_en && ((^cap) ^ pbit ^ par_odd);
    end

    // Receive data register and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n || mrst) begin
            rdrf <= 1'b0;
            fe   <= 1'b0;
            pe   <= 1'b0;
            ovrn <= 1'b0;
            dreg <= '0;
        end else if (done) begin
            if (rdrf && !rd) begin
                ovrn <= 1'b1;
            end else begin
                dreg <= cap;
                rdrf <= 1'b1;
                fe   <= !s2;
                pe   <= pe_calc;
                ovrn <= 1'b0;
            end
        end else if (rd) begin
            rdrf <= 1'b0;
            fe   <= 1'b0;
            pe   <= 1'b0;
            ovrn <= 1'b0;
        end
    end

    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        rd && !done |=> !rdrf) else $error("AST_READ_EMPTIES"); // R8
    AST_ERR_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (fe || pe || ovrn) |-> rdrf) else $error("AST_ERR_NEEDS_DATA"); // R9
    AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        done && rdrf && !rd && !mrst |=> ovrn && $stable(dreg)) else $error("AST_OVERRUN_KEEPS"); // R10

endmodule

// File: rtl/sio_adapter.sv
// Serial adapter top: control decode, transmitter, receiver and status byte.
// Assumes one register strobe per cycle from the surrounding decoder.
module sio_adapter
    import sio_pkg::*;
#(
    parameter int P_X1  = 1,
    parameter int P_X16 = 16,
    parameter int P_X64 = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic       txd_we,
    input  logic       rxd_rd,
    input  logic [7:0] wdata,
    output logic [7:0] status,
    output logic [7:0] rx_byte,
    input  logic       rx_line,
    output logic       tx_line,
    output logic       rts_out,
    input  logic       dcd_in,
    input  logic       cts_in,
    output logic       irq
);

    localparam int CNT_W = $clog2(P_X64 + 1);

    logic             mrst, brk, rx_ie, tx_ie, single;
    fmt_t             fmt;
    logic [CNT_W-1:0] bit_last, half_last;
    logic             tdre, rdrf, fe, pe, ovrn;

    sio_ctrl #(.P_X1(P_X1), .P_X16(P_X16), .P_X64(P_X64)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(wdata),
        .mrst(mrst), .brk(brk), .rts(rts_out), .rx_ie(rx_ie), .tx_ie(tx_ie),
        .fmt(fmt), .bit_last(bit_last), .half_last(half_last), .single(single)
    );

    sio_tx #(.CNT_W(CNT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .mrst(mrst), .brk(brk), .fmt(fmt),
        .bit_last(bit_last), .we(txd_we), .wdata(wdata),
        .txd(tx_line), .tdre(tdre)
    );

    sio_rx #(.CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .mrst(mrst), .d8(fmt.d8), .par_en(fmt.par_en),
        .par_odd(fmt.par_odd), .bit_last(bit_last), .half_last(half_last),
        .single(single), .rxd(rx_line), .rd(rxd_rd),
        .rdrf(rdrf), .fe(fe), .pe(pe), .ovrn(ovrn), .dreg(rx_byte)
    );

    logic rdrf_v, fe_v, pe_v, ovrn_v;

    // Status assembly; receive flags read as zero while in master reset.
    always_comb begin
        rdrf_v = rdrf && !mrst;
        fe_v   = fe && !mrst;
        pe_v   = pe && !mrst;
        ovrn_v = ovrn && !mrst;
        irq    = (rx_ie && rdrf_v) || (tx_ie && tdre);
        status = {irq, pe_v, ovrn_v, fe_v, cts_in, dcd_in, tdre, rdrf_v};
    end

    AST_BREAK_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we && (wdata[6:5] == 2'b11) |=> !tx_line) else $error("AST_BREAK_FORCES_LOW"); // R5
    AST_MRST_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we && (wdata[1:0] == 2'b11) |=> ((status & 8'hF3) == 8'h00)) else $error("AST_MRST_CLEARS_FLAGS"); // R2
    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status[0] || status[1])) else $error("AST_IRQ_HAS_SOURCE"); // R11

endmodule

// File: tb/sim_sio_adapter.sv
`timescale 1ns/1ps
module sim_sio_adapter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0, txd_we = 1'b0, rxd_rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] status, rx_byte;
    logic       tx_line, rts_out, irq;
    logic       dcd_in = 1'b0, cts_in = 1'b0;
    logic       loop_en = 1'b0, rx_drv = 1'b1;
    logic       rx_line;
    int         checks = 0, errors = 0;

    assign rx_line = loop_en ? tx_line : rx_drv;

    always #2.5 clk = ~clk;

    sio_adapter u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .txd_we(txd_we), .rxd_rd(rxd_rd),
        .wdata(wdata), .status(status), .rx_byte(rx_byte), .rx_line(rx_line),
        .tx_line(tx_line), .rts_out(rts_out), .dcd_in(dcd_in), .cts_in(cts_in), .irq(irq)
    );

    // Vectors: {format code, byte sent, byte expected back}.
    localparam logic [18:0] VEC [8] = '{
        {3'd0, 8'hD5, 8'h55}, {3'd1, 8'hBC, 8'h3C}, {3'd2, 8'h7F, 8'h7F},
        {3'd3, 8'h80, 8'h00}, {3'd4, 8'hA5, 8'hA5}, {3'd5, 8'hFF, 8'hFF},
        {3'd6, 8'h81, 8'h81}, {3'd7, 8'h6E, 8'h6E}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        wdata = v; ctrl_we = 1'b1;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic wr_tx(input logic [7:0] v);
        wdata = v; txd_we = 1'b1;
        @(negedge clk);
        txd_we = 1'b0;
    endtask

    task automatic rd_pulse();
        rxd_rd = 1'b1;
        @(negedge clk);
        rxd_rd = 1'b0;
    endtask

    // Frame expected on the line for a format code and byte (R4 layout).
    function automatic int mk_frame(input logic [2:0] f, input logic [7:0] d,
                                    input bit flip_par, output logic [11:0] fr);
        int   dl;
        bit   pen, two;
        logic p;
        dl  = f[2] ? 8 : 7;
        pen = (f != 3'd4) && (f != 3'd5);
        two = (f == 3'd0) || (f == 3'd1) || (f == 3'd4);
        fr  = '1;
        fr[0] = 1'b0;
        p = f[0] ^ flip_par;
        for (int i = 0; i < dl; i++) begin
            fr[1 + i] = d[i];
            p = p ^ d[i];
        end
        if (pen) fr[1 + dl] = p;
        return 1 + dl + (pen ? 1 : 0) + (two ? 2 : 1);
    endfunction

    task automatic send_frame(input logic [11:0] fr, input int nb, input int per);
        for (int k = 0; k < nb; k++) begin
            rx_drv = fr[k];
            tick(per);
        end
        rx_drv = 1'b1;
    endtask

    task automatic wait_fall();
        for (int i = 0; i < 3000 && tx_line !== 1'b0; i++) @(negedge clk);
    endtask

    task automatic wait_full();
        for (int i = 0; i < 3000 && status[0] !== 1'b1; i++) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [11:0] fr, got;
        int          nb, n;
        tick(4);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 status", status, 8'h00);
        chk("R1 tx_line", tx_line, 1'b1);
        chk("R1 rts", rts_out, 1'b0);
        // R12 modem inputs
        dcd_in = 1'b1; #1; chk("R12 dcd", status, 8'h04);
        dcd_in = 1'b0; cts_in = 1'b1; #1; chk("R12 cts", status, 8'h08);
        cts_in = 1'b0;
        // R2 resume from master reset
        wr_ctrl(8'h15);
        chk("R2 resume", status, 8'h02);
        // R11 transmit interrupt
        wr_ctrl(8'h35);
        chk("R11 tx irq", {irq, status}, {1'b1, 8'h82});
        wr_ctrl(8'h15);
        chk("R11 irq off", irq, 1'b0);
        // R5 RTS and break
        wr_ctrl(8'h55);
        chk("R5 rts high", rts_out, 1'b1);
        wr_ctrl(8'h75);
        chk("R5 break low", {rts_out, tx_line}, 2'b00);
        tick(100);
        chk("R5 break held", tx_line, 1'b0);
        wr_ctrl(8'h15);
        chk("R5 break end", tx_line, 1'b1);

        // R4 table walk in loopback at divide 16
        loop_en = 1'b1;
        for (int v = 0; v < 8; v++) begin
            wr_ctrl({3'b000, VEC[v][18:16], 2'b01});
            nb = mk_frame(VEC[v][18:16], VEC[v][15:8], 1'b0, fr);
            wr_tx(VEC[v][15:8]);
            wait_fall();
            tick(8);
            got = '1;
            for (int k = 0; k < nb; k++) begin
                got[k] = tx_line;
                if (k < nb - 1) tick(16);
            end
            chk($sformatf("R4 frame fmt%0d", v), got, fr);
            wait_full();
            chk($sformatf("R4 status fmt%0d", v), status, 8'h03);
            chk($sformatf("R4 byte fmt%0d", v), rx_byte, {24'h0, VEC[v][7:0]});
            rd_pulse();
            tick(40);
        end

        // R3 bit period for each divide code, with loopback receive
        for (int dc = 0; dc < 3; dc++) begin
            wr_ctrl({6'b000101, 2'(dc)});
            wr_tx(8'h01);
            wait_fall();
            n = 0;
            while (tx_line === 1'b0 && n < 200) begin n++; @(negedge clk); end
            chk($sformatf("R3 period div%0d", dc), n, (dc == 0) ? 1 : (dc == 1) ? 16 : 64);
            wait_full();
            chk($sformatf("R3 rx div%0d", dc), rx_byte, 8'h01);
            rd_pulse();
            tick(200);
        end
        loop_en = 1'b0;

        // R7 false start rejected, then a real character
        wr_ctrl(8'h15);
        rx_drv = 1'b0; tick(5); rx_drv = 1'b1;
        tick(60);
        chk("R7 no char", status[0], 1'b0);
        nb = mk_frame(3'd5, 8'hA5, 1'b0, fr);
        send_frame(fr, nb, 16);
        chk("R7 good char", {status, rx_byte}, {8'h03, 8'hA5});
        rd_pulse();
        chk("R8 read clears", status, 8'h02);

        // R9 framing error
        nb = mk_frame(3'd5, 8'h3C, 1'b0, fr);
        fr[9] = 1'b0;
        send_frame(fr, nb, 16);
        tick(40);
        chk("R9 framing", status, 8'h13);
        rd_pulse();
        chk("R8 clears fe", status, 8'h02);
        // R9 parity error in 8E1
        wr_ctrl(8'h19);
        nb = mk_frame(3'd6, 8'h07, 1'b1, fr);
        send_frame(fr, nb, 16);
        chk("R9 parity", {status, rx_byte}, {8'h43, 8'h07});
        rd_pulse();
        chk("R8 clears pe", status, 8'h02);

        // R10 overrun keeps first byte
        wr_ctrl(8'h15);
        nb = mk_frame(3'd5, 8'h11, 1'b0, fr);
        send_frame(fr, nb, 16);
        nb = mk_frame(3'd5, 8'h22, 1'b0, fr);
        send_frame(fr, nb, 16);
        chk("R10 overrun", {status, rx_byte}, {8'h23, 8'h11});
        rd_pulse();
        chk("R10 cleared", status, 8'h02);

        // R11 receive interrupt
        wr_ctrl(8'h95);
        nb = mk_frame(3'd5, 8'h5A, 1'b0, fr);
        send_frame(fr, nb, 16);
        chk("R11 rx irq", {irq, status}, {1'b1, 8'h83});
        rd_pulse();
        chk("R11 rx irq off", irq, 1'b0);

        // R2 master reset clears flags, idles and drops transmit writes
        wr_ctrl(8'h15);
        nb = mk_frame(3'd5, 8'h33, 1'b0, fr);
        send_frame(fr, nb, 16);
        chk("R2 pending", status[0], 1'b1);
        wr_ctrl(8'h17);
        chk("R2 flags clear", status, 8'h00);
        wr_tx(8'h00);
        tick(5);
        chk("R2 line idle a", tx_line, 1'b1);
        tick(45);
        chk("R2 line idle b", tx_line, 1'b1);
        wr_ctrl(8'h15);
        chk("R2 write dropped", {status, tx_line}, {8'h02, 1'b1});

        // R6 transmit empty with a queued second byte at divide 64
        wr_ctrl(8'h16);
        wr_tx(8'h55);
        wr_tx(8'hAA);
        chk("R6 queued", status[1], 1'b0);
        tick(300);
        chk("R6 still queued", status[1], 1'b0);
        tick(400);
        chk("R6 taken", status[1], 1'b1);
        tick(10);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule